// File: doc/BRIEF.md
# Link Status Hardware Poll Engine

This block reads a receiver's two-byte link status word over a DDC read port, so that software does not have to poll it. The bit-level I2C engine and the bus arbiter sit outside. They are reached through a simple handshake: the block raises a request and holds it until the request is accepted. Later a completion pulse arrives, carrying the data and four error bits.

A two-bit mode selects when reads happen. The modes are: off; loop only while the link is flagged authenticated; loop unconditionally; or start on a software strobe and loop until a chosen status field meets its condition. Between reads, the looping modes wait for an expiry pulse from an external per-line request timer.

Each read result is folded into one 32-bit interrupt word. The word holds the captured fields and sticky event flags. Each event has an enable bit and a write-one-to-acknowledge bit. One interrupt output is the OR of every enabled flag. A separate 16-bit word reports the error bits of the most recent transaction.

Top module: `link_status_poller`

## Requirements
- R1: After reset no request is raised, `irq` is 0, and both `irq_word` and `err_word` are zero.
- R2: With `poll_mode` 0 no request is issued, whatever `timer_tick` or `sw_trig` do. Setting `poll_mode` to 0 drops `ddc_req` in the next cycle, and a completion arriving after that is ignored.
- R3: With `poll_mode` 1, polling happens only while `link_authed` is 1. After each completion the block waits for a `timer_tick` before the next request. If `link_authed` is 0 when the block is waiting, it goes idle.
- R4: With `poll_mode` 2, a request is issued regardless of `link_authed`. After each completion the next request waits for a `timer_tick`.
- R5: With `poll_mode` 3, the block stays idle until `sw_trig` is pulsed. It then reads, and repeats on each `timer_tick`. It goes idle as soon as an enabled message-size, ready or reauth interrupt is pending.
- R6: A good read loads status bits 9:0 into `irq_word[29:20]`. The size interrupt (enable at bit 31) fires only while that field is nonzero. Writing 1 to bit 30 clears the field to zero.
- R7: Status bit 10 is the ready bit. A good read that sees 1 sets flag bit 16, and one that sees 0 sets flag bit 15. The ready enable at bits 19:18 interrupts on bit 16 when it is 1, on bit 15 when it is 2, and on either when it is 3. Writing 1 to bit 17 clears both flags.
- R8: Status bit 11 is the reauth bit. When it reads 1, flag bit 12 is set. The enable is at bit 14 and the acknowledge at bit 13.
- R9: `ddc_req` stays high until `ddc_accept`. An accepted request sets flag bit 0 (enable 2, acknowledge 1). Every completion sets flag bit 4 (enable 6, acknowledge 5).
- R10: Each completion writes `ddc_err` bit 0 (NACK0) to `err_word[12]`, bit 1 (NACK1) to bit 14, bit 2 (timeout) to bit 4, and bit 3 (abort) to bit 8. Any nonzero error sets failed flag bit 8 (enable 10, acknowledge 9) and leaves the size, ready and reauth fields unchanged.
- R11: With `full_read` 1, `ddc_two_byte` is 1 and the whole word is captured. With `full_read` 0, `ddc_two_byte` is 0 and only `irq_word[27:20]` is loaded, from status bits 7:0.
- R12: `irq` is the OR of every set flag whose enable is set. A write loads all enable fields. Acknowledge bits read back as 0. A flag set by an event in the same cycle as its acknowledge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_mode | input | 2 | 0 off, 1 loop while authenticated, 2 loop always, 3 strobe-started loop |
| full_read | input | 1 | 1 disables short reads (two-byte reads) |
| link_authed | input | 1 | Link authenticated flag, gates mode 1 |
| sw_trig | input | 1 | Software start strobe for mode 3 |
| timer_tick | input | 1 | Request-timer expiry pulse |
| irq_wr_en | input | 1 | Write strobe for the interrupt word |
| irq_wr_data | input | 32 | Enables and acknowledge bits to write |
| irq_word | output | 32 | Interrupt control/status word |
| irq | output | 1 | OR of enabled pending flags |
| err_word | output | 16 | Error bits of the last transaction |
| ddc_req | output | 1 | Read request to the DDC arbiter |
| ddc_two_byte | output | 1 | 1 = read two bytes, 0 = one byte |
| ddc_accept | input | 1 | Request accepted |
| ddc_done | input | 1 | Transaction complete |
| ddc_rdata | input | 16 | Status word read from the receiver |
| ddc_err | input | 4 | {abort, timeout, NACK1, NACK0} |

## Verification
The hardest situation to reach is a mode-3 loop that must end by itself: the stop depends on a field captured on an earlier read, and it must win over a timer tick arriving in the same cycle. The bench runs strobe-started loops. The first reads return a zero size or the wrong ready polarity, so the loop continues. A later read satisfies the enabled condition, and the bench then pulses a tick at once to confirm that no further request follows. An acknowledge that coincides with a completion is produced by writing the interrupt word in the exact cycle the completion pulse is driven.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int SIZE_W   = 10;
    localparam int STAT_W   = 16;
    localparam int IWORD_W  = 32;
    localparam int ERR_W    = 16;
    localparam int ERRIN_W  = 4;

    // raw status word layout
    localparam int ST_SIZE_LSB  = 0;
    localparam int ST_READY     = 10;
    localparam int ST_REAUTH    = 11;
    localparam int SHORT_W      = 8;

    // interrupt word layout
    localparam int IW_SZ_EN     = 31;
    localparam int IW_SZ_ACK    = 30;
    localparam int IW_SZ_LSB    = 20;
    localparam int IW_RDY_EN    = 18;
    localparam int IW_RDY_ACK   = 17;
    localparam int IW_RDY_ONE   = 16;
    localparam int IW_RDY_ZERO  = 15;
    localparam int IW_RA_EN     = 14;
    localparam int IW_RA_ACK    = 13;
    localparam int IW_RA_FLAG   = 12;
    localparam int IW_FL_EN     = 10;
    localparam int IW_FL_ACK    = 9;
    localparam int IW_FL_FLAG   = 8;
    localparam int IW_DN_EN     = 6;
    localparam int IW_DN_ACK    = 5;
    localparam int IW_DN_FLAG   = 4;
    localparam int IW_RQ_EN     = 2;
    localparam int IW_RQ_ACK    = 1;
    localparam int IW_RQ_FLAG   = 0;

    // error word layout
    localparam int EW_NACK0     = 12;
    localparam int EW_NACK1     = 14;
    localparam int EW_TMO       = 4;
    localparam int EW_ABORT     = 8;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_AUTH  = 2'd1,
        MODE_FORCE = 2'd2,
        MODE_TRIG  = 2'd3
    } poll_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_WAIT,
        SQ_GAP
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              rdy_one;
        logic              rdy_zero;
        logic              reauth;
        logic              fail;
        logic              done;
        logic              req;
        logic              en_size;
        logic [1:0]        en_rdy;
        logic              en_reauth;
        logic              en_fail;
        logic              en_done;
        logic              en_req;
    } irq_regs_t;

endpackage

// File: rtl/lsp_sequencer.sv
module lsp_sequencer
    import lsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       link_authed_i,
    input  logic       sw_trig_i,
    input  logic       timer_tick_i,
    input  logic       field_irq_i,
    input  logic       ddc_accept_i,
    input  logic       ddc_done_i,
    output logic       ddc_req_o,
    output logic       req_fire_o,
    output logic       rd_done_o
);

    seq_regs_t seq_d, seq_q;
    poll_mode_e mode;

    assign mode = poll_mode_e'(mode_i);

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            SQ_IDLE: begin
                case (mode)
                    MODE_AUTH:  if (link_authed_i) seq_d.st = SQ_REQ;
                    MODE_FORCE: seq_d.st = SQ_REQ;
                    MODE_TRIG:  if (sw_trig_i) seq_d.st = SQ_REQ;
                    default:    seq_d.st = SQ_IDLE;
                endcase
            end
            SQ_REQ:  if (ddc_accept_i) seq_d.st = SQ_WAIT;
            SQ_WAIT: if (ddc_done_i) seq_d.st = SQ_GAP;
            SQ_GAP: begin
                case (mode)
                    MODE_AUTH: begin
                        if (!link_authed_i)    seq_d.st = SQ_IDLE;
                        else if (timer_tick_i) seq_d.st = SQ_REQ;
                    end
                    MODE_FORCE: if (timer_tick_i) seq_d.st = SQ_REQ;
                    MODE_TRIG: begin
                        if (field_irq_i)       seq_d.st = SQ_IDLE;
                        else if (timer_tick_i) seq_d.st = SQ_REQ;
                    end
                    default: seq_d.st = SQ_IDLE;
                endcase
            end
            default: seq_d.st = SQ_IDLE;
        endcase
        if (mode == MODE_OFF) seq_d.st = SQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SQ_IDLE};
        else        seq_q <= seq_d;
    end

    assign ddc_req_o  = (seq_q.st == SQ_REQ);
    assign req_fire_o = (seq_q.st == SQ_REQ) && ddc_accept_i;
    assign rd_done_o  = (seq_q.st == SQ_WAIT) && ddc_done_i && (mode != MODE_OFF);

    // R2: turning the mode off drops the request on the next cycle
    assert_off_drops_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> !ddc_req_o);

    // R9: an unaccepted request is held
    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ddc_req_o && !ddc_accept_i && mode_i != MODE_OFF) |=> ddc_req_o);

    // R3: no request leaves idle in mode 1 without the link flag
    assert_auth_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_IDLE && mode_i == MODE_AUTH && !link_authed_i) |=> !ddc_req_o);

    // R5: mode 3 waits for the strobe while idle
    assert_trig_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_IDLE && mode_i == MODE_TRIG && !sw_trig_i) |=> !ddc_req_o);

endmodule

// File: rtl/lsp_irq_regs.sv
module lsp_irq_regs
    import lsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IWORD_W-1:0] wr_data_i,
    input  logic               req_fire_i,
    input  logic               rd_done_i,
    input  logic [STAT_W-1:0]  rd_data_i,
    input  logic [ERRIN_W-1:0] rd_err_i,
    input  logic               full_read_i,
    output logic [IWORD_W-1:0] irq_word_o,
    output logic               field_irq_o,
    output logic               irq_o
);

    irq_regs_t ir_d, ir_q;
    logic      rdy_hit;
    logic      data_unused;

    assign data_unused = ^rd_data_i[STAT_W-1:ST_REAUTH+1];

    always_comb begin
        ir_d = ir_q;
        if (wr_en_i) begin
            ir_d.en_size   = wr_data_i[IW_SZ_EN];
            ir_d.en_rdy    = wr_data_i[IW_RDY_EN +: 2];
            ir_d.en_reauth = wr_data_i[IW_RA_EN];
            ir_d.en_fail   = wr_data_i[IW_FL_EN];
            ir_d.en_done   = wr_data_i[IW_DN_EN];
            ir_d.en_req    = wr_data_i[IW_RQ_EN];
            if (wr_data_i[IW_SZ_ACK])  ir_d.size = '0;
            if (wr_data_i[IW_RDY_ACK]) begin
                ir_d.rdy_one  = 1'b0;
                ir_d.rdy_zero = 1'b0;
            end
            if (wr_data_i[IW_RA_ACK])  ir_d.reauth = 1'b0;
            if (wr_data_i[IW_FL_ACK])  ir_d.fail   = 1'b0;
            if (wr_data_i[IW_DN_ACK])  ir_d.done   = 1'b0;
            if (wr_data_i[IW_RQ_ACK])  ir_d.req    = 1'b0;
        end
        if (req_fire_i) ir_d.req = 1'b1;
        if (rd_done_i) begin
            ir_d.done = 1'b1;
            if (|rd_err_i) begin
                ir_d.fail = 1'b1;
            end else if (full_read_i) begin
                ir_d.size     = rd_data_i[ST_SIZE_LSB +: SIZE_W];
                ir_d.rdy_one  = ir_d.rdy_one  |  rd_data_i[ST_READY];
                ir_d.rdy_zero = ir_d.rdy_zero | ~rd_data_i[ST_READY];
                ir_d.reauth   = ir_d.reauth   |  rd_data_i[ST_REAUTH];
            end else begin
                ir_d.size[SHORT_W-1:0] = rd_data_i[ST_SIZE_LSB +: SHORT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    always_comb begin
        irq_word_o = '0;
        irq_word_o[IW_SZ_EN]             = ir_q.en_size;
        irq_word_o[IW_SZ_LSB +: SIZE_W]  = ir_q.size;
        irq_word_o[IW_RDY_EN +: 2]       = ir_q.en_rdy;
        irq_word_o[IW_RDY_ONE]           = ir_q.rdy_one;
        irq_word_o[IW_RDY_ZERO]          = ir_q.rdy_zero;
        irq_word_o[IW_RA_EN]             = ir_q.en_reauth;
        irq_word_o[IW_RA_FLAG]           = ir_q.reauth;
        irq_word_o[IW_FL_EN]             = ir_q.en_fail;
        irq_word_o[IW_FL_FLAG]           = ir_q.fail;
        irq_word_o[IW_DN_EN]             = ir_q.en_done;
        irq_word_o[IW_DN_FLAG]           = ir_q.done;
        irq_word_o[IW_RQ_EN]             = ir_q.en_req;
        irq_word_o[IW_RQ_FLAG]           = ir_q.req;
    end

    assign rdy_hit     = (ir_q.en_rdy[0] & ir_q.rdy_one) | (ir_q.en_rdy[1] & ir_q.rdy_zero);
    assign field_irq_o = (ir_q.en_size & (|ir_q.size)) | rdy_hit | (ir_q.en_reauth & ir_q.reauth);
    assign irq_o       = field_irq_o | (ir_q.en_fail & ir_q.fail) |
                         (ir_q.en_done & ir_q.done) | (ir_q.en_req & ir_q.req);

    // R10: an erroring completion raises the failed flag
    assert_fail_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && (|rd_err_i)) |=> irq_word_o[IW_FL_FLAG]);

    // R10: an erroring completion leaves the size field alone
    assert_fail_keeps_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && (|rd_err_i) && !(wr_en_i && wr_data_i[IW_SZ_ACK]))
        |=> $stable(irq_word_o[IW_SZ_LSB +: SIZE_W]));

    // R6: a good full read lands its size bits in the word
    assert_size_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && rd_err_i == '0 && full_read_i)
        |=> irq_word_o[IW_SZ_LSB +: SIZE_W] == $past(rd_data_i[ST_SIZE_LSB +: SIZE_W]));

    // R9: acknowledging done without a new completion clears it
    assert_done_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[IW_DN_ACK] && !rd_done_i) |=> !irq_word_o[IW_DN_FLAG]);

endmodule

// File: rtl/lsp_err_status.sv
module lsp_err_status
    import lsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_done_i,
    input  logic [ERRIN_W-1:0] rd_err_i,
    output logic [ERR_W-1:0]   err_word_o
);

    logic [ERR_W-1:0] err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (rd_done_i) begin
            err_d = '0;
            err_d[EW_NACK0] = rd_err_i[0];
            err_d[EW_NACK1] = rd_err_i[1];
            err_d[EW_TMO]   = rd_err_i[2];
            err_d[EW_ABORT] = rd_err_i[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_word_o = err_q;

    // R10: the error word changes only at a completion
    assert_err_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done_i |=> $stable(err_word_o));

endmodule

// File: rtl/link_status_poller.sv
module link_status_poller
    import lsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         poll_mode,
    input  logic               full_read,
    input  logic               link_authed,
    input  logic               sw_trig,
    input  logic               timer_tick,
    input  logic               irq_wr_en,
    input  logic [IWORD_W-1:0] irq_wr_data,
    output logic [IWORD_W-1:0] irq_word,
    output logic               irq,
    output logic [ERR_W-1:0]   err_word,
    output logic               ddc_req,
    output logic               ddc_two_byte,
    input  logic               ddc_accept,
    input  logic               ddc_done,
    input  logic [STAT_W-1:0]  ddc_rdata,
    input  logic [ERRIN_W-1:0] ddc_err
);

    logic req_fire;
    logic rd_done;
    logic field_irq;

    lsp_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (poll_mode),
        .link_authed_i (link_authed),
        .sw_trig_i     (sw_trig),
        .timer_tick_i  (timer_tick),
        .field_irq_i   (field_irq),
        .ddc_accept_i  (ddc_accept),
        .ddc_done_i    (ddc_done),
        .ddc_req_o     (ddc_req),
        .req_fire_o    (req_fire),
        .rd_done_o     (rd_done)
    );

    lsp_irq_regs u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (irq_wr_en),
        .wr_data_i   (irq_wr_data),
        .req_fire_i  (req_fire),
        .rd_done_i   (rd_done),
        .rd_data_i   (ddc_rdata),
        .rd_err_i    (ddc_err),
        .full_read_i (full_read),
        .irq_word_o  (irq_word),
        .field_irq_o (field_irq),
        .irq_o       (irq)
    );

    lsp_err_status u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_done_i  (rd_done),
        .rd_err_i   (ddc_err),
        .err_word_o (err_word)
    );

    assign ddc_two_byte = full_read;

endmodule

// File: tb/link_status_poller_tb.sv
module link_status_poller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ACK_ALL  = 32'h4002_2222;
    localparam logic [31:0] ACK_KEEP = 32'h0002_2222;
    localparam logic [31:0] FL_REQ_DONE = 32'h0000_0011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  poll_mode = 2'd0;
    logic        full_read = 1'b1;
    logic        link_authed = 1'b0;
    logic        sw_trig = 1'b0;
    logic        timer_tick = 1'b0;
    logic        irq_wr_en = 1'b0;
    logic [31:0] irq_wr_data = '0;
    logic [31:0] irq_word;
    logic        irq;
    logic [15:0] err_word;
    logic        ddc_req;
    logic        ddc_two_byte;
    logic        ddc_accept = 1'b0;
    logic        ddc_done = 1'b0;
    logic [15:0] ddc_rdata = '0;
    logic [3:0]  ddc_err = '0;

    int total = 0;
    int bad = 0;
    logic seen_two;
    logic [9:0] last_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_status_poller dut_i (
        .clk(clk), .rst_n(rst_n), .poll_mode(poll_mode), .full_read(full_read),
        .link_authed(link_authed), .sw_trig(sw_trig), .timer_tick(timer_tick),
        .irq_wr_en(irq_wr_en), .irq_wr_data(irq_wr_data), .irq_word(irq_word),
        .irq(irq), .err_word(err_word), .ddc_req(ddc_req), .ddc_two_byte(ddc_two_byte),
        .ddc_accept(ddc_accept), .ddc_done(ddc_done), .ddc_rdata(ddc_rdata),
        .ddc_err(ddc_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        irq_wr_en = 1'b1; irq_wr_data = v;
        @(negedge clk);
        irq_wr_en = 1'b0; irq_wr_data = '0;
    endtask

    task automatic tick();
        timer_tick = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0;
    endtask

    task automatic trig();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic no_req(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(tag, {31'd0, ddc_req}, 32'd0);
        end
    endtask

    // R9 handshake: wait for request, accept, then complete
    task automatic serve(input string tag, input logic [15:0] d, input logic [3:0] e);
        int n = 0;
        while (!ddc_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " request seen"}, {31'd0, ddc_req}, 32'd1);
        seen_two = ddc_two_byte;
        ddc_accept = 1'b1;
        @(negedge clk);
        ddc_accept = 1'b0;
        ddc_done = 1'b1; ddc_rdata = d; ddc_err = e;
        @(negedge clk);
        ddc_done = 1'b0; ddc_rdata = '0; ddc_err = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 irq_word", irq_word, 32'd0);
        chk("R1 err_word", {16'd0, err_word}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 ddc_req", {31'd0, ddc_req}, 32'd0);

        // R2: mode off ignores ticks and strobes
        tick(); trig(); tick();
        no_req("R2 off mode", 6);

        // R6 R7 R8 R9 R12 sweep in mode 2
        poll_mode = 2'd2;
        for (int i = 0; i < 1024; i++) begin
            logic [4:0]  j;
            logic [9:0]  sz;
            logic        rdy, ra;
            logic [31:0] ew;
            logic        ei;
            j   = 5'((i * 37 + 5) & 31);
            sz  = 10'(i);
            rdy = sz[3] ^ sz[7];
            ra  = sz[2] ^ sz[8];
            wr(ACK_ALL | ({31'd0, j[0]} << 31) | ({30'd0, j[2:1]} << 18) |
               ({31'd0, j[3]} << 14) | ({31'd0, j[4]} << 6));
            tick();
            serve("R4 sweep", {4'd0, ra, rdy, sz}, 4'd0);
            ew = ({22'd0, sz} << 20) | ({31'd0, j[0]} << 31) | ({30'd0, j[2:1]} << 18) |
                 (rdy ? 32'h0001_0000 : 32'h0000_8000) | ({31'd0, j[3]} << 14) |
                 ({31'd0, ra} << 12) | ({31'd0, j[4]} << 6) | FL_REQ_DONE;
            ei = (j[0] && sz != 0) || (j[1] && rdy) || (j[2] && !rdy) || (j[3] && ra) || j[4];
            chk("R6 R7 R8 R9 word", irq_word, ew);
            chk("R12 irq", {31'd0, irq}, {31'd0, ei});
        end
        last_size = 10'd1023;

        // R12: acknowledge coinciding with a completion keeps the flag
        wr(ACK_ALL);
        tick();
        begin
            int n = 0;
            while (!ddc_req && n < 50) begin @(negedge clk); n++; end
        end
        ddc_accept = 1'b1;
        @(negedge clk);
        ddc_accept = 1'b0;
        ddc_done = 1'b1; ddc_rdata = 16'h0003;
        irq_wr_en = 1'b1; irq_wr_data = 32'h0000_0020;
        @(negedge clk);
        ddc_done = 1'b0; ddc_rdata = '0; irq_wr_en = 1'b0; irq_wr_data = '0;
        last_size = 10'd3;
        chk("R12 set wins over ack", {31'd0, irq_word[4]}, 32'd1);
        wr(32'h0000_0020);
        chk("R9 done ack clears", {31'd0, irq_word[4]}, 32'd0);
        chk("R12 ack bits read zero", irq_word & ACK_ALL, 32'd0);

        // R10: error sweep
        for (int e = 0; e < 16; e++) begin
            logic [3:0]  ee;
            logic [9:0]  sz;
            logic        rdy, ra;
            logic [31:0] ew;
            ee  = 4'(e);
            sz  = 10'(100 + e);
            ra  = ee[0];
            rdy = ~ee[1];
            wr(ACK_KEEP);
            tick();
            serve("R10 err", {4'd0, ra, rdy, sz}, ee);
            if (ee == 0) last_size = sz;
            ew = ({22'd0, last_size} << 20) | FL_REQ_DONE;
            if (ee == 0) ew = ew | (rdy ? 32'h0001_0000 : 32'h0000_8000) | ({31'd0, ra} << 12);
            else         ew = ew | 32'h0000_0100;
            chk("R10 word", irq_word, ew);
            chk("R10 err_word", {16'd0, err_word},
                ({31'd0, ee[0]} << 12) | ({31'd0, ee[1]} << 14) |
                ({31'd0, ee[2]} << 4) | ({31'd0, ee[3]} << 8));
        end

        // R11: short read
        full_read = 1'b0;
        wr(ACK_KEEP);
        tick();
        serve("R11 short", 16'hFFAB, 4'd0);
        chk("R11 two_byte low", {31'd0, seen_two}, 32'd0);
        chk("R11 short word", irq_word, ({22'd0, last_size[9:8], 8'hAB} << 20) | FL_REQ_DONE);
        full_read = 1'b1;
        wr(ACK_ALL);
        tick();
        serve("R11 full", 16'h0000, 4'd0);
        chk("R11 two_byte high", {31'd0, seen_two}, 32'd1);

        // R3: mode 1
        poll_mode = 2'd0;
        @(negedge clk);
        wr(ACK_ALL);
        link_authed = 1'b0;
        poll_mode = 2'd1;
        no_req("R3 not authed", 6);
        link_authed = 1'b1;
        @(negedge clk);
        serve("R3 first", 16'h0001, 4'd0);
        no_req("R3 waits tick", 4);
        tick();
        serve("R3 second", 16'h0002, 4'd0);
        chk("R3 size", {22'd0, irq_word[29:20]}, 32'd2);
        link_authed = 1'b0;
        tick();
        no_req("R3 auth lost", 6);

        // R4: mode 2 ignores link flag
        poll_mode = 2'd2;
        @(negedge clk);
        serve("R4 start", 16'h0005, 4'd0);
        no_req("R4 waits tick", 4);
        tick();
        serve("R4 again", 16'h0006, 4'd0);
        chk("R4 size", {22'd0, irq_word[29:20]}, 32'd6);

        // R5: mode 3 with size enable
        poll_mode = 2'd0;
        @(negedge clk);
        wr(ACK_ALL | 32'h8000_0000);
        poll_mode = 2'd3;
        no_req("R5 waits strobe", 5);
        trig();
        serve("R5 first", 16'h0000, 4'd0);
        no_req("R5 waits tick", 4);
        tick();
        serve("R5 size hit", 16'h0007, 4'd0);
        tick();
        no_req("R5 stopped on size", 6);
        chk("R5 irq", {31'd0, irq}, 32'd1);
        chk("R5 word", irq_word, 32'h8000_0000 | (32'd7 << 20) | 32'h0000_8000 | FL_REQ_DONE);

        // R5 / R7: mode 3 with ready==0 enable
        wr(ACK_ALL | (32'd2 << 18));
        trig();
        serve("R7 ready one", 16'h0400, 4'd0);
        chk("R7 no irq on ready one", {31'd0, irq}, 32'd0);
        tick();
        serve("R7 ready zero", 16'h0000, 4'd0);
        tick();
        no_req("R5 stopped on ready", 6);
        chk("R7 irq ready zero", {31'd0, irq}, 32'd1);
        chk("R7 word", irq_word, (32'd2 << 18) | 32'h0001_8000 | FL_REQ_DONE);

        // R2: abort drops the request, late completion ignored
        poll_mode = 2'd0;
        @(negedge clk);
        wr(ACK_ALL);
        poll_mode = 2'd2;
        @(negedge clk);
        chk("R2 req before abort", {31'd0, ddc_req}, 32'd1);
        poll_mode = 2'd0;
        @(negedge clk);
        chk("R2 req dropped", {31'd0, ddc_req}, 32'd0);
        ddc_done = 1'b1; ddc_rdata = 16'hFFFF; ddc_err = 4'hF;
        @(negedge clk);
        ddc_done = 1'b0; ddc_rdata = '0; ddc_err = '0;
        @(negedge clk);
        chk("R2 late done word", irq_word, 32'd0);
        chk("R2 late done err", {16'd0, err_word}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule